// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a segment-relative memory reference into a 20-bit physical address. It keeps four 16-bit segment bases (code, data, stack, extra) that are loaded through a write port. On each request it picks a segment and a 16-bit offset, shifts the segment base left by four bits, adds the offset, and registers the result.

Requests come in two kinds. An instruction fetch always pairs the code segment with the instruction pointer. A data access builds its offset from operand-mode inputs. The offset can be a displacement alone, a base register value, an index register value, or the sum of base, index and displacement. The segment for a data access is the data segment unless the base register is a stack-type register, in which case the stack segment is used. An explicit override input takes priority over both defaults.

Register values arrive as plain input ports. Instruction decode, the bus cycle and the register file sit outside this block.

Top module: `segAddrGen`

## Requirements
- R1: While reset is active and on the first cycle after it, `addrValid` is 0 and `physAddr` is 0. All four segment bases reset to 0000H.
- R2: The physical address is (segment × 16 + offset) modulo 2^20. Any carry out of bit 19 is dropped, so segment FFFFH with offset 0010H gives 00000H.
- R3: A pulse on `segWrEn` loads `segWrData` into the segment chosen by `segWrSel`, with 0 = code, 1 = data, 2 = stack and 3 = extra. The new value is used by requests from the next cycle onward. A request in the same cycle as the write still uses the old value.
- R4: For data accesses, `modeSel` sets the offset as follows: 0 gives `disp`, 1 gives `baseVal`, 2 gives `indexVal`, and 3 gives `baseVal + indexVal + disp` truncated to 16 bits.
- R5: When `reqIsFetch` is 1, the request uses the code segment with `ipIn` as the offset. In that case `modeSel`, `ovrEn` and `baseIsStack` have no effect.
- R6: A data access with no override and no stack-type base uses the data segment. For example, data segment 2000H with offset 0050H gives 20050H.
- R7: A data access with `baseIsStack` = 1 in mode 1 or 3, and no override, uses the stack segment. In modes 0 and 2 it uses the data segment.
- R8: For a data access, `ovrEn` = 1 selects the segment given by `ovrSel` (same encoding as R3), whatever the default would have been.
- R9: `addrValid` is 1 exactly in the cycle after a `reqValid` cycle. `physAddr` keeps its value through cycles with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| segWrEn | input | 1 | Segment base write strobe |
| segWrSel | input | 2 | Segment to write (0 code, 1 data, 2 stack, 3 extra) |
| segWrData | input | 16 | New segment base |
| reqValid | input | 1 | Address request strobe |
| reqIsFetch | input | 1 | 1 = instruction fetch, 0 = data access |
| ipIn | input | 16 | Instruction pointer offset for fetches |
| modeSel | input | 2 | Offset mode for data accesses |
| baseVal | input | 16 | Base register value |
| indexVal | input | 16 | Index register value |
| disp | input | 16 | Displacement from the instruction |
| baseIsStack | input | 1 | Base register is a stack-type register |
| ovrEn | input | 1 | Segment override enable |
| ovrSel | input | 2 | Override segment |
| physAddr | output | 20 | Registered physical address |
| addrValid | output | 1 | Address valid strobe |

## Verification
The assertions assume that reset is held low for at least one clock and that `reqValid` is low during reset. Under that assumption, the first post-reset check of the one-cycle latency compares against a known-zero request.

The checker keeps its own shadow copies of the code and data bases from the write port. This relies on all segment writes passing through that port after reset.

The bench drives every input at the falling edge and keeps reset low during its reset window. The random stimulus covers all values of `modeSel`, `ovrSel` and `segWrSel`, so every input combination it produces lies inside what the assertions assume.

// File: rtl/segAddrPkg.sv
package segAddrPkg;
  typedef enum logic [1:0] {
    SEG_CODE  = 2'd0,
    SEG_DATA  = 2'd1,
    SEG_STACK = 2'd2,
    SEG_EXTRA = 2'd3
  } segId_e;

  typedef enum logic [1:0] {
    MODE_DISP  = 2'd0,
    MODE_BASE  = 2'd1,
    MODE_INDEX = 2'd2,
    MODE_BIX   = 2'd3
  } offMode_e;

  typedef struct packed {
    logic   load;
    segId_e segSel;
    logic   useIp;
    logic   useBase;
    logic   useIndex;
    logic   useDisp;
  } addrStrobes_t;
endpackage

// File: rtl/addrCtrl.sv
module addrCtrl
  import segAddrPkg::*;
(
  input  logic         reqValid,
  input  logic         reqIsFetch,
  input  logic [1:0]   modeSel,
  input  logic         baseIsStack,
  input  logic         ovrEn,
  input  logic [1:0]   ovrSel,
  output addrStrobes_t strobes
);
  offMode_e mode;
  assign mode = offMode_e'(modeSel);

  always_comb begin
    strobes = '0;
    strobes.load = reqValid;
    if (reqIsFetch) begin
      strobes.segSel = SEG_CODE;
      strobes.useIp  = 1'b1;
    end else begin
      strobes.useBase  = (mode == MODE_BASE)  || (mode == MODE_BIX);
      strobes.useIndex = (mode == MODE_INDEX) || (mode == MODE_BIX);
      strobes.useDisp  = (mode == MODE_DISP)  || (mode == MODE_BIX);
      if (ovrEn)
        strobes.segSel = segId_e'(ovrSel);
      else if (baseIsStack && strobes.useBase)
        strobes.segSel = SEG_STACK;
      else
        strobes.segSel = SEG_DATA;
    end
  end
endmodule

// File: rtl/addrDatapath.sv
module addrDatapath
  import segAddrPkg::*;
#(
  parameter int OFS_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int SEG_COUNT = 4,
  localparam int PHYS_W   = OFS_W + SEG_SHIFT,
  localparam int SEL_W    = $clog2(SEG_COUNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              segWrEn,
  input  logic [SEL_W-1:0]  segWrSel,
  input  logic [OFS_W-1:0]  segWrData,
  input  addrStrobes_t      strobes,
  input  logic [OFS_W-1:0]  ipIn,
  input  logic [OFS_W-1:0]  baseVal,
  input  logic [OFS_W-1:0]  indexVal,
  input  logic [OFS_W-1:0]  disp,
  output logic [PHYS_W-1:0] physAddr,
  output logic              addrValid
);
  logic [OFS_W-1:0]  segBank [SEG_COUNT];
  logic [OFS_W-1:0]  segVal;
  logic [OFS_W-1:0]  effAddr;
  logic [PHYS_W-1:0] physNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < SEG_COUNT; i++) segBank[i] <= '0;
    end else if (segWrEn) begin
      segBank[segWrSel] <= segWrData;
    end
  end

  assign segVal = segBank[SEL_W'(strobes.segSel)];

  always_comb begin
    effAddr = '0;
    if (strobes.useIp)    effAddr = effAddr + ipIn;
    if (strobes.useBase)  effAddr = effAddr + baseVal;
    if (strobes.useIndex) effAddr = effAddr + indexVal;
    if (strobes.useDisp)  effAddr = effAddr + disp;
  end

  assign physNext = {segVal, {SEG_SHIFT{1'b0}}} + PHYS_W'(effAddr);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      physAddr  <= '0;
      addrValid <= 1'b0;
    end else begin
      addrValid <= strobes.load;
      if (strobes.load) physAddr <= physNext;
    end
  end
endmodule

// File: rtl/segAddrGen.sv
module segAddrGen
  import segAddrPkg::*;
#(
  parameter int OFS_W     = 16,
  parameter int SEG_SHIFT = 4,
  localparam int PHYS_W   = OFS_W + SEG_SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              segWrEn,
  input  logic [1:0]        segWrSel,
  input  logic [OFS_W-1:0]  segWrData,
  input  logic              reqValid,
  input  logic              reqIsFetch,
  input  logic [OFS_W-1:0]  ipIn,
  input  logic [1:0]        modeSel,
  input  logic [OFS_W-1:0]  baseVal,
  input  logic [OFS_W-1:0]  indexVal,
  input  logic [OFS_W-1:0]  disp,
  input  logic              baseIsStack,
  input  logic              ovrEn,
  input  logic [1:0]        ovrSel,
  output logic [PHYS_W-1:0] physAddr,
  output logic              addrValid
);
  addrStrobes_t strobes;

  addrCtrl uCtrl (
    .reqValid   (reqValid),
    .reqIsFetch (reqIsFetch),
    .modeSel    (modeSel),
    .baseIsStack(baseIsStack),
    .ovrEn      (ovrEn),
    .ovrSel     (ovrSel),
    .strobes    (strobes)
  );

  addrDatapath #(
    .OFS_W    (OFS_W),
    .SEG_SHIFT(SEG_SHIFT),
    .SEG_COUNT(4)
  ) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .segWrEn  (segWrEn),
    .segWrSel (segWrSel),
    .segWrData(segWrData),
    .strobes  (strobes),
    .ipIn     (ipIn),
    .baseVal  (baseVal),
    .indexVal (indexVal),
    .disp     (disp),
    .physAddr (physAddr),
    .addrValid(addrValid)
  );
endmodule

// File: rtl/segAddrGenChecker.sv
module segAddrGenChecker (
  input logic        clk,
  input logic        rstN,
  input logic        segWrEn,
  input logic [1:0]  segWrSel,
  input logic [15:0] segWrData,
  input logic        reqValid,
  input logic        reqIsFetch,
  input logic [15:0] ipIn,
  input logic [1:0]  modeSel,
  input logic [15:0] disp,
  input logic        ovrEn,
  input logic [19:0] physAddr,
  input logic        addrValid
);
  logic [15:0] shadowCode;
  logic [15:0] shadowData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowCode <= '0;
      shadowData <= '0;
    end else if (segWrEn) begin
      if (segWrSel == 2'd0) shadowCode <= segWrData;
      if (segWrSel == 2'd1) shadowData <= segWrData;
    end
  end

  assert_valid_latency_R9: assert property (@(posedge clk) disable iff (!rstN)
    addrValid == $past(reqValid));

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> $stable(physAddr));

  assert_fetch_nibble_R5: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqIsFetch |=> physAddr[3:0] == $past(ipIn[3:0]));

  assert_fetch_addr_R5: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqIsFetch |=>
      physAddr == ({$past(shadowCode), 4'h0} + {4'h0, $past(ipIn)}));

  assert_direct_default_R6: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqIsFetch && modeSel == 2'd0 && !ovrEn |=>
      physAddr == ({$past(shadowData), 4'h0} + {4'h0, $past(disp)}));
endmodule

bind segAddrGen segAddrGenChecker uCheck (
  .clk       (clk),
  .rstN      (rstN),
  .segWrEn   (segWrEn),
  .segWrSel  (segWrSel),
  .segWrData (segWrData),
  .reqValid  (reqValid),
  .reqIsFetch(reqIsFetch),
  .ipIn      (ipIn),
  .modeSel   (modeSel),
  .disp      (disp),
  .ovrEn     (ovrEn),
  .physAddr  (physAddr),
  .addrValid (addrValid)
);

// File: tb/tb_segAddrGen.sv
module tb_segAddrGen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        segWrEn = 1'b0;
  logic [1:0]  segWrSel = '0;
  logic [15:0] segWrData = '0;
  logic        reqValid = 1'b0;
  logic        reqIsFetch = 1'b0;
  logic [15:0] ipIn = '0;
  logic [1:0]  modeSel = '0;
  logic [15:0] baseVal = '0;
  logic [15:0] indexVal = '0;
  logic [15:0] disp = '0;
  logic        baseIsStack = 1'b0;
  logic        ovrEn = 1'b0;
  logic [1:0]  ovrSel = '0;
  logic [19:0] physAddr;
  logic        addrValid;

  int total = 0;
  int bad = 0;
  logic [15:0] segModel [4];
  logic [19:0] lastExp = '0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  segAddrGen dut (.*);

  function automatic logic [19:0] modelAddr(
      input logic fetch, input logic [15:0] ip, input logic [1:0] mode,
      input logic [15:0] b, input logic [15:0] x, input logic [15:0] d,
      input logic stk, input logic ov, input logic [1:0] ovs);
    logic [15:0] off;
    logic [1:0]  s;
    if (fetch) begin
      off = ip; s = 2'd0;
    end else begin
      case (mode)
        2'd0: off = d;
        2'd1: off = b;
        2'd2: off = x;
        default: off = b + x + d;
      endcase
      if (ov) s = ovs;
      else if (stk && (mode == 2'd1 || mode == 2'd3)) s = 2'd2;
      else s = 2'd1;
    end
    return 20'(segModel[s] * 20'd16 + {4'h0, off});
  endfunction

  task automatic check(input string req, input logic [19:0] act, input logic [19:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%05h expected=%05h", req, act, exp);
    end
  endtask

  // one cycle: optional write and optional request, then check outputs
  task automatic step(input string req, input logic we, input logic [1:0] ws,
      input logic [15:0] wd, input logic rv, input logic fetch,
      input logic [15:0] ip, input logic [1:0] mode, input logic [15:0] b,
      input logic [15:0] x, input logic [15:0] d, input logic stk,
      input logic ov, input logic [1:0] ovs);
    logic [19:0] exp;
    @(negedge clk);
    segWrEn = we; segWrSel = ws; segWrData = wd;
    reqValid = rv; reqIsFetch = fetch; ipIn = ip; modeSel = mode;
    baseVal = b; indexVal = x; disp = d; baseIsStack = stk;
    ovrEn = ov; ovrSel = ovs;
    exp = rv ? modelAddr(fetch, ip, mode, b, x, d, stk, ov, ovs) : lastExp;
    if (we) segModel[ws] = wd;
    @(posedge clk); #1;
    segWrEn = 1'b0; reqValid = 1'b0;
    check({req, " valid"}, {19'd0, addrValid}, {19'd0, rv});
    check(req, physAddr, exp);
    lastExp = exp;
  endtask

  task automatic wrSeg(input logic [1:0] s, input logic [15:0] v);
    step("R3", 1'b1, s, v, 1'b0, 1'b0, 16'h0, 2'd0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0, 2'd0);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) segModel[i] = '0;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset valid", {19'd0, addrValid}, 20'd0);
    check("R1 reset addr", physAddr, 20'd0);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    check("R1 post-reset valid", {19'd0, addrValid}, 20'd0);
    // R1 segments zero: fetch at ip 1234 gives 01234
    step("R1 seg zero", 0, 0, 0, 1, 1, 16'h1234, 0, 0, 0, 0, 0, 0, 0);
    // R6 classic example
    wrSeg(2'd1, 16'h2000);
    step("R6 2000:0050", 0, 0, 0, 1, 0, 0, 2'd0, 0, 0, 16'h0050, 0, 0, 0);
    check("R6 literal", physAddr, 20'h20050);
    // R2 wrap
    wrSeg(2'd3, 16'hFFFF);
    step("R2 wrap", 0, 0, 0, 1, 0, 0, 2'd0, 0, 0, 16'h0010, 0, 1, 2'd3);
    check("R2 literal", physAddr, 20'h00000);
    // R4 truncated sum
    step("R4 ea wrap", 0, 0, 0, 1, 0, 0, 2'd3, 16'hFFFF, 16'h0002, 16'h0000, 0, 0, 0);
    check("R4 literal", physAddr, 20'h20001);
    // R7 stack default vs index mode
    wrSeg(2'd2, 16'h3000);
    step("R7 stack base", 0, 0, 0, 1, 0, 0, 2'd1, 16'h0100, 0, 0, 1, 0, 0);
    check("R7 literal", physAddr, 20'h30100);
    step("R7 index mode data", 0, 0, 0, 1, 0, 0, 2'd2, 16'h0100, 16'h0040, 0, 1, 0, 0);
    // R8 override beats stack default
    step("R8 override", 0, 0, 0, 1, 0, 0, 2'd1, 16'h0008, 0, 0, 1, 1, 2'd0);
    // R5 fetch ignores override
    wrSeg(2'd0, 16'hF000);
    step("R5 fetch", 0, 0, 0, 1, 1, 16'hFFF0, 2'd3, 16'h1111, 16'h2222, 16'h3333, 1, 1, 2'd2);
    check("R5 literal", physAddr, 20'hFFFF0);
    // R3 same-cycle write uses old base, next uses new
    step("R3 same cycle old", 1, 2'd1, 16'h4000, 1, 0, 0, 2'd0, 0, 0, 16'h0004, 0, 0, 0);
    check("R3 old literal", physAddr, 20'h20004);
    step("R3 next new", 0, 0, 0, 1, 0, 0, 2'd0, 0, 0, 16'h0004, 0, 0, 0);
    check("R3 new literal", physAddr, 20'h40004);
    // R9 hold while idle
    step("R9 idle hold", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    check("R9 hold literal", physAddr, 20'h40004);
    // random mix
    for (int n = 0; n < 400; n++) begin
      step("R2/R4/R8 random", $urandom_range(0, 3) == 0, 2'($urandom),
           16'($urandom), $urandom_range(0, 3) != 0, $urandom_range(0, 4) == 0,
           16'($urandom), 2'($urandom), 16'($urandom), 16'($urandom),
           16'($urandom), 1'($urandom), $urandom_range(0, 3) == 0, 2'($urandom));
    end
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule